// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

This block takes a signed three-digit decimal reading and shows it one digit at a time on a single shared 4-bit BCD bus. Three active-low digit-select lines name the digit on the bus: most significant (MSD), next significant (NSD) and least significant (LSD). An external decoder and digit drivers turn bus and selects into a lit display. Each pulse on the scan tick input moves the scan one position. Before a new digit is driven, the selects are released for one clock, so a digit never shows the code meant for its neighbour.

Two special codes outside the decimal range replace digit data. Code 1010 is a dash and code 1011 is an "E". A reading above full scale shows "EEE" and a reading below the negative range shows three dashes. A small negative reading shows a dash in the MSD position, with its magnitude in the other two digits. The reading is taken once per frame, when the scan returns to the MSD, so one frame never mixes two readings.

Top module: `bcd_digit_scan`

## Requirements
- R1: While reset is asserted, and after it is released until the first scan tick, `sel_n` is 3'b111 and `bcd_out` is 4'b0000.
- R2: Bit 2 of `sel_n` selects the MSD, bit 1 the NSD and bit 0 the LSD. At most one bit is low at a time. Accepted ticks select MSD, NSD, LSD, MSD and so on, one step per tick, and the first tick after reset selects the MSD.
- R3: A tick accepted at a clock edge drives `sel_n` to 3'b111 and places the new digit's code on `bcd_out` at that edge. The new select goes low one edge later. `bcd_out` changes only in a cycle where all selects are high.
- R4: A tick seen during the one-clock blanking cycle is ignored. The scan does not skip a position.
- R5: With no sign and no overrange, MSD, NSD and LSD carry the hundreds, tens and ones digits unchanged.
- R6: With the sign input high and no overrange, the MSD carries 1010 (dash), the NSD carries the tens digit and the LSD carries the ones digit. The hundreds digit is ignored.
- R7: With negative overrange high and positive overrange low, all three digits carry 1010, whatever the sign and digit inputs are.
- R8: With positive overrange high, all three digits carry 1011. Positive overrange takes priority over negative overrange and over the sign.
- R9: Reading inputs are sampled only at the tick that selects the MSD. Changes during the NSD and LSD steps of a frame do not appear until the next frame.
- R10: Between accepted ticks, `bcd_out` and `sel_n` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_tick | input | 1 | One-clock pulse that advances the scan one digit |
| dig_hund | input | 4 | Hundreds digit of the reading, BCD |
| dig_tens | input | 4 | Tens digit of the reading, BCD |
| dig_ones | input | 4 | Ones digit of the reading, BCD |
| sign_neg | input | 1 | Reading is negative |
| over_pos | input | 1 | Reading is above the positive range |
| over_neg | input | 1 | Reading is below the negative range |
| bcd_out | output | 4 | Shared BCD bus for the selected digit |
| sel_n | output | 3 | Active-low digit selects {MSD, NSD, LSD} |

## Verification
The bench checks the code priority with both overrange flags and the sign set together. A design that let the dash win would show "---" for a reading that is really too high. It changes the reading in the middle of a frame; a design that sampled the inputs on every tick would show a torn frame. It sends a tick during the blanking cycle, which a design that accepts ticks there would answer by skipping straight to the NSD. It also checks a negative reading with a nonzero hundreds digit, which catches a design that puts the hundreds digit in the MSD instead of the dash.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;

    localparam int BCD_W = 4;
    localparam int N_DIG = 3;
    localparam int POS_W = $clog2(N_DIG);

    localparam logic [BCD_W-1:0] CODE_DASH = 4'b1010;
    localparam logic [BCD_W-1:0] CODE_OVER = 4'b1011;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BLANK = 2'd1,
        PH_SHOW  = 2'd2
    } phase_e;

    // position 0 is the most significant digit
    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        logic [BCD_W-1:0] hund;
        logic [BCD_W-1:0] tens;
        logic [BCD_W-1:0] ones;
        logic             minus;
        logic             ovr_hi;
        logic             ovr_lo;
    } reading_t;

    typedef struct packed {
        phase_e phase;
        pos_t   pos;
    } seq_state_t;

    typedef struct packed {
        logic [BCD_W-1:0] bcd;
        logic [N_DIG-1:0] sel_n;
    } drive_t;

endpackage

// File: rtl/scan_seq.sv
module scan_seq
    import bcd_scan_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    output phase_e phase,
    output pos_t   pos,
    output pos_t   next_pos,
    output logic   step,
    output logic   frame_start
);

    seq_state_t seq_d, seq_q;

    always_comb begin
        step = tick && (seq_q.phase != PH_BLANK);
        if (seq_q.phase == PH_IDLE || seq_q.pos == pos_t'(N_DIG - 1)) begin
            next_pos = '0;
        end else begin
            next_pos = seq_q.pos + pos_t'(1);
        end
        frame_start = step && (next_pos == '0);

        seq_d = seq_q;
        if (step) begin
            seq_d.phase = PH_BLANK;
            seq_d.pos   = next_pos;
        end else if (seq_q.phase == PH_BLANK) begin
            seq_d.phase = PH_SHOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, pos: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase = seq_q.phase;
    assign pos   = seq_q.pos;

endmodule

// File: rtl/frame_hold.sv
module frame_hold
    import bcd_scan_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  reading_t live,
    output reading_t view
);

    reading_t held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (load) begin
            held_d = live;
        end
        // the first digit of a frame is taken straight from the live inputs
        view = load ? live : held_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            held_q <= held_d;
        end
    end

endmodule

// File: rtl/digit_code.sv
module digit_code
    import bcd_scan_pkg::*;
(
    input  reading_t         rd,
    input  pos_t             pos,
    output logic [BCD_W-1:0] code
);

    always_comb begin
        if (rd.ovr_hi) begin
            code = CODE_OVER;
        end else if (rd.ovr_lo) begin
            code = CODE_DASH;
        end else begin
            case (pos)
                pos_t'(0): code = rd.minus ? CODE_DASH : rd.hund;
                pos_t'(1): code = rd.tens;
                default:   code = rd.ones;
            endcase
        end
    end

endmodule

// File: rtl/bcd_digit_scan.sv
module bcd_digit_scan
    import bcd_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scan_tick,
    input  logic [3:0] dig_hund,
    input  logic [3:0] dig_tens,
    input  logic [3:0] dig_ones,
    input  logic       sign_neg,
    input  logic       over_pos,
    input  logic       over_neg,
    output logic [3:0] bcd_out,
    output logic [2:0] sel_n
);

    phase_e           phase;
    pos_t             pos;
    pos_t             next_pos;
    logic             step;
    logic             frame_start;
    reading_t         live;
    reading_t         view;
    logic [BCD_W-1:0] code;
    logic [N_DIG-1:0] sel_show;
    drive_t           drv_d, drv_q;

    assign live = '{hund: dig_hund, tens: dig_tens, ones: dig_ones,
                    minus: sign_neg, ovr_hi: over_pos, ovr_lo: over_neg};

    scan_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (scan_tick),
        .phase       (phase),
        .pos         (pos),
        .next_pos    (next_pos),
        .step        (step),
        .frame_start (frame_start)
    );

    frame_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_start),
        .live  (live),
        .view  (view)
    );

    digit_code u_code (
        .rd   (view),
        .pos  (next_pos),
        .code (code)
    );

    // MSD sits in the top bit of the select vector
    for (genvar g = 0; g < N_DIG; g++) begin : g_sel
        assign sel_show[N_DIG-1-g] = (pos != pos_t'(g));
    end

    always_comb begin
        drv_d = drv_q;
        if (step) begin
            drv_d.bcd   = code;
            drv_d.sel_n = '1;
        end else if (phase == PH_BLANK) begin
            drv_d.sel_n = sel_show;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '{bcd: '0, sel_n: '1};
        end else begin
            drv_q <= drv_d;
        end
    end

    assign bcd_out = drv_q.bcd;
    assign sel_n   = drv_q.sel_n;

endmodule

// File: rtl/scan_checker.sv
module scan_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scan_tick,
    input logic [3:0] bcd_out,
    input logic [2:0] sel_n
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (sel_n == 3'b111 && bcd_out == 4'b0000));

    assert_one_digit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n));

    assert_order_nsd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n[1]) |-> $past(sel_n, 2) == 3'b011);

    assert_order_lsd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n[0]) |-> $past(sel_n, 2) == 3'b101);

    assert_order_msd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n[2]) |-> ($past(sel_n, 2) == 3'b110 || $past(sel_n, 2) == 3'b111));

    assert_bus_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bcd_out) |-> sel_n == 3'b111);

    assert_blank_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n != 3'b111 && !$stable(sel_n)) |-> $past(sel_n) == 3'b111);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(scan_tick) && !$past(scan_tick, 2)) |-> ($stable(bcd_out) && $stable(sel_n)));

endmodule

bind bcd_digit_scan scan_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_tick (scan_tick),
    .bcd_out   (bcd_out),
    .sel_n     (sel_n)
);

// File: tb/sim_bcd_digit_scan.sv
`timescale 1ns/1ps
module sim_bcd_digit_scan;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_tick = 1'b0;
    logic [3:0] dig_hund = '0;
    logic [3:0] dig_tens = '0;
    logic [3:0] dig_ones = '0;
    logic       sign_neg = 1'b0;
    logic       over_pos = 1'b0;
    logic       over_neg = 1'b0;
    logic [3:0] bcd_out;
    logic [2:0] sel_n;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    bcd_digit_scan u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_tick (scan_tick),
        .dig_hund  (dig_hund),
        .dig_tens  (dig_tens),
        .dig_ones  (dig_ones),
        .sign_neg  (sign_neg),
        .over_pos  (over_pos),
        .over_neg  (over_neg),
        .bcd_out   (bcd_out),
        .sel_n     (sel_n)
    );

    // {hund, tens, ones, sign, ovr_pos, ovr_neg, exp_msd, exp_nsd, exp_lsd}
    localparam int NV = 7;
    localparam logic [26:0] VECS [NV] = '{
        {4'd1, 4'd2, 4'd3, 3'b000, 4'd1,  4'd2,  4'd3 },
        {4'd9, 4'd0, 4'd9, 3'b000, 4'd9,  4'd0,  4'd9 },
        {4'd0, 4'd9, 4'd9, 3'b100, 4'hA,  4'd9,  4'd9 },
        {4'd7, 4'd4, 4'd2, 3'b100, 4'hA,  4'd4,  4'd2 },
        {4'd5, 4'd5, 4'd5, 3'b001, 4'hA,  4'hA,  4'hA },
        {4'd3, 4'd3, 4'd3, 3'b111, 4'hB,  4'hB,  4'hB },
        {4'd0, 4'd0, 4'd0, 3'b010, 4'hB,  4'hB,  4'hB }
    };

    localparam logic [2:0] SEL_EXP [3] = '{3'b011, 3'b101, 3'b110};

    task automatic chk(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_reading(input logic [3:0] h, t, o, input logic s, p, n);
        dig_hund = h; dig_tens = t; dig_ones = o;
        sign_neg = s; over_pos = p; over_neg = n;
    endtask

    // one tick; check the blanking cycle, then the selected cycle
    task automatic step_check(input string req, input int idx, input logic [3:0] exp);
        @(negedge clk) scan_tick = 1'b1;
        @(negedge clk) scan_tick = 1'b0;
        chk("R3", "blank sel", {1'b0, sel_n}, 4'b0111);
        chk(req, "bus in blank", bcd_out, exp);
        @(negedge clk);
        chk("R2", "sel", {1'b0, sel_n}, {1'b0, SEL_EXP[idx]});
        chk(req, "bus shown", bcd_out, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "sel in reset", {1'b0, sel_n}, 4'b0111);
        chk("R1", "bus in reset", bcd_out, 4'b0000);
        rst_n = 1'b1;
        set_reading(4'd8, 4'd8, 4'd8, 1'b0, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        chk("R1", "sel before tick", {1'b0, sel_n}, 4'b0111);
        chk("R1", "bus before tick", bcd_out, 4'b0000);

        // table walk: R5..R8 code selection
        for (int v = 0; v < NV; v++) begin
            logic [26:0] e;
            string tag;
            e = VECS[v];
            set_reading(e[26:23], e[22:19], e[18:15], e[14], e[13], e[12]);
            tag = e[13] ? "R8" : (e[12] ? "R7" : (e[14] ? "R6" : "R5"));
            step_check(tag, 0, e[11:8]);
            step_check(tag, 1, e[7:4]);
            step_check(tag, 2, e[3:0]);
        end

        // R10: display holds with no tick (LSD of last vector)
        repeat (6) @(negedge clk);
        chk("R10", "sel hold", {1'b0, sel_n}, 4'b0110);
        chk("R10", "bus hold", bcd_out, 4'hB);

        // R9: mid-frame change is deferred to next frame
        set_reading(4'd1, 4'd2, 4'd3, 1'b0, 1'b0, 1'b0);
        step_check("R9", 0, 4'd1);
        set_reading(4'd4, 4'd5, 4'd6, 1'b0, 1'b1, 1'b0);
        step_check("R9", 1, 4'd2);
        step_check("R9", 2, 4'd3);
        set_reading(4'd4, 4'd5, 4'd6, 1'b0, 1'b0, 1'b0);

        // R4: tick held into the blanking cycle must not skip a digit
        @(negedge clk) scan_tick = 1'b1;
        @(negedge clk);
        @(negedge clk) scan_tick = 1'b0;
        chk("R4", "sel after double tick", {1'b0, sel_n}, 4'b0011);
        chk("R9", "new frame msd", bcd_out, 4'd4);
        step_check("R4", 1, 4'd5);
        step_check("R9", 2, 4'd6);

        // R1: reset in the middle of a scan
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "sel after reset", {1'b0, sel_n}, 4'b0111);
        chk("R1", "bus after reset", bcd_out, 4'b0000);
        rst_n = 1'b1;
        set_reading(4'd0, 4'd0, 4'd7, 1'b0, 1'b0, 1'b0);
        step_check("R2", 0, 4'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule